// File: doc/BRIEF.md
# Analog Output Card Register Bank

This block is the host-side register file of a multichannel analog output card. A 16-bit host bus addresses a 32-byte window of even-aligned 16-bit registers. The block presents the bus as a 4-bit word index, so the word index is the byte offset divided by two. Each access completes in the cycle it is presented. There is no back-pressure and no wait state, so the bus carries no valid/ready pair: a one-cycle `bus_wr` or `bus_rd` pulse is the whole transaction.

Writes are decoded into several targets:
- three configuration words;
- a digital output latch;
- a bank of DAC channel registers;
- a FIFO write strobe;
- write-to-clear strobes for three interrupt flags.

Reads return the digital input lines or a status word, or raise a FIFO-clear strobe. A bank-select bit in the main configuration word changes what happens at the low offsets. While it is set, writes at those offsets clear interrupt flags. It also steers the shared offset 0x0C from the FIFO to DAC channel 0.

The DAC registers hold 12-bit two's-complement values and are also shown as offset-binary codes. The number of channels is a parameter (6 or 10). The FIFO memory, the converters, the interval timer and DMA transfers sit outside the block. Only the FIFO flags, the FIFO strobes, the event inputs and the decoded state cross its edge.

Top module: `aoc_regbank`

## Requirements
- R1: After reset, all three configuration words, the digital output latch, every DAC register and all three interrupt flags are zero. The normal bank is selected and `dio_oe` is zero, so all lines are inputs.
- R2: With configuration-1 bit 7 clear, a write at byte offset 0x00, 0x02, 0x04 or 0x0A updates the digital output latch (low 8 bits), configuration 2, configuration 3 or configuration 1 respectively, visible the cycle after the write. Writes at 0x0A always reach configuration 1, whatever the bank.
- R3: With configuration-1 bit 7 set, a write at 0x00, 0x02 or 0x04 clears the terminal-count flag, INT1 or INT2 respectively. The digital output latch, configuration 2 and configuration 3 keep their values.
- R4: A write at 0x0C in the normal bank raises `fifo_wr_stb` in that cycle with `fifo_wdata` equal to the written word, and leaves DAC 0 unchanged. In the alternate bank the same write loads DAC 0 and raises no FIFO strobe.
- R5: A write at offset 0x0C + 2n, for 1 <= n < NCH, loads bits 11:0 into DAC n in either bank. Writes at offsets for channel NCH and above change no DAC register.
- R6: `dac_code` shows each DAC register as offset binary: the stored two's-complement value with bit 11 inverted, so a stored 0x000 reads as 0x800.
- R7: A read at 0x0C raises `fifo_clr_stb` in that cycle and changes no register.
- R8: A read at 0x0A returns the status word: bit 6 FIFO half-full, bit 5 FIFO empty, bit 4 FIFO full, bit 3 INT2, bit 2 INT1, bit 1 terminal count, bit 0 serial PROM output, upper bits zero.
- R9: A read at 0x00 returns `dio_in` in bits 7:0 with zeros above. Configuration-3 bit 2 drives `dio_oe[3:0]` and bit 3 drives `dio_oe[7:4]`.
- R10: A one-cycle event input sets its interrupt flag on the next cycle. A clear strobe for the same flag in the same cycle wins, and the flag reads zero.
- R11: Writes at the timer offsets 0x06 and 0x08 change no output, and reads at offsets other than 0x00 and 0x0A return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | 4 | Word index (byte offset / 2) |
| bus_wr | input | 1 | Write pulse |
| bus_rd | input | 1 | Read pulse |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| prom_dout | input | 1 | Serial PROM data output |
| ev_tc | input | 1 | Terminal-count event pulse |
| ev_int1 | input | 1 | Interrupt 1 event pulse |
| ev_int2 | input | 1 | Interrupt 2 event pulse |
| fifo_wr_stb | output | 1 | FIFO write strobe |
| fifo_wdata | output | 16 | Word for the FIFO |
| fifo_clr_stb | output | 1 | FIFO clear strobe |
| cfg1_q | output | 16 | Configuration 1 (bit 7 bank select) |
| cfg2_q | output | 16 | Configuration 2 |
| cfg3_q | output | 16 | Configuration 3 |
| flag_tc | output | 1 | Terminal-count flag |
| flag_int1 | output | 1 | Interrupt 1 flag |
| flag_int2 | output | 1 | Interrupt 2 flag |
| dac_vals | output | NCH*12 | DAC registers, two's complement, channel n at bits 12n+11:12n |
| dac_code | output | NCH*12 | DAC registers as offset-binary codes |
| dio_in | input | 8 | Digital input lines |
| dio_out | output | 8 | Digital output latch |
| dio_oe | output | 8 | Per-line output enables |

## Verification
The assertions check a few rules on every cycle:
- a clear in the alternate bank always leaves its flag low, even when an event arrives at the same time;
- an event without a clear always sets its flag;
- a normal-bank write at 0x02 loads configuration 2, and an alternate-bank write there leaves it unchanged;
- the two FIFO strobes appear only for the matching access at 0x0C and, for the write strobe, only in the right bank.

Other behaviour can only be shown by the bench's scenarios:
- the mapping of each offset to its DAC channel, and which channel offsets are ignored;
- the offset-binary view of the DAC registers;
- the layout of the status word;
- the nibble grouping of the output enables.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  localparam int DW    = 16;
  localparam int WA_W  = 4;
  localparam int DAC_W = 12;

  // word indexes (byte offset / 2)
  localparam logic [WA_W-1:0] WI_DIO   = 4'd0;
  localparam logic [WA_W-1:0] WI_CFG2  = 4'd1;
  localparam logic [WA_W-1:0] WI_CFG3  = 4'd2;
  localparam logic [WA_W-1:0] WI_CFG1  = 4'd5;
  localparam logic [WA_W-1:0] WI_SHARE = 4'd6;

  localparam int BANK_BIT  = 7;
  localparam int OE_LO_BIT = 2;
  localparam int OE_HI_BIT = 3;

  localparam int FLG_TC   = 0;
  localparam int FLG_INT1 = 1;
  localparam int FLG_INT2 = 2;
  localparam int NFLG     = 3;

  typedef struct packed {
    logic wr_dout;
    logic wr_cfg1;
    logic wr_cfg2;
    logic wr_cfg3;
    logic fifo_wr;
    logic fifo_clr;
    logic [NFLG-1:0] clr;
  } strobes_t;
endpackage

// File: rtl/aoc_decode.sv
module aoc_decode
  import aoc_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic [WA_W-1:0] waddr,
  input  logic            wr,
  input  logic            rd,
  input  logic            bank,
  output strobes_t        stb,
  output logic [NCH-1:0]  dac_we
);
  always_comb begin
    stb = '0;
    if (wr) begin
      unique case (waddr)
        WI_DIO:   if (bank) stb.clr[FLG_TC]   = 1'b1; else stb.wr_dout = 1'b1;
        WI_CFG2:  if (bank) stb.clr[FLG_INT1] = 1'b1; else stb.wr_cfg2 = 1'b1;
        WI_CFG3:  if (bank) stb.clr[FLG_INT2] = 1'b1; else stb.wr_cfg3 = 1'b1;
        WI_CFG1:  stb.wr_cfg1 = 1'b1;
        WI_SHARE: if (!bank) stb.fifo_wr = 1'b1;
        default:  ;
      endcase
    end
    if (rd && waddr == WI_SHARE) stb.fifo_clr = 1'b1;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_we
    localparam logic [WA_W-1:0] WI_CH = WA_W'(int'(WI_SHARE) + n);
    if (n == 0) begin : g_ch0
      assign dac_we[n] = wr && bank && (waddr == WI_CH);
    end else begin : g_chn
      assign dac_we[n] = wr && (waddr == WI_CH);
    end
  end
endmodule

// File: rtl/aoc_flag.sv
module aoc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (ev)  q <= 1'b1;
  end
endmodule

// File: rtl/aoc_dac_bank.sv
module aoc_dac_bank
  import aoc_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       we,
  input  logic [DAC_W-1:0]     wdata,
  output logic [NCH*DAC_W-1:0] vals,
  output logic [NCH*DAC_W-1:0] codes
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [DAC_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)     r <= '0;
      else if (we[n]) r <= wdata;
    end
    assign vals[n*DAC_W +: DAC_W]  = r;
    assign codes[n*DAC_W +: DAC_W] = r ^ MID;
  end
endmodule

// File: rtl/aoc_regbank.sv
module aoc_regbank
  import aoc_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            bus_waddr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic                  fifo_half,
  input  logic                  fifo_empty,
  input  logic                  fifo_full,
  input  logic                  prom_dout,
  input  logic                  ev_tc,
  input  logic                  ev_int1,
  input  logic                  ev_int2,
  output logic                  fifo_wr_stb,
  output logic [15:0]           fifo_wdata,
  output logic                  fifo_clr_stb,
  output logic [15:0]           cfg1_q,
  output logic [15:0]           cfg2_q,
  output logic [15:0]           cfg3_q,
  output logic                  flag_tc,
  output logic                  flag_int1,
  output logic                  flag_int2,
  output logic [NCH*12-1:0]     dac_vals,
  output logic [NCH*12-1:0]     dac_code,
  input  logic [7:0]            dio_in,
  output logic [7:0]            dio_out,
  output logic [7:0]            dio_oe
);
  localparam int DIO_W = 8;
  localparam int HALF  = DIO_W / 2;

  strobes_t         stb;
  logic [NCH-1:0]   dac_we;
  logic [NFLG-1:0]  ev_v;
  logic [NFLG-1:0]  flg;

  aoc_decode #(.NCH(NCH)) u_dec (
    .waddr  (bus_waddr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .bank   (cfg1_q[BANK_BIT]),
    .stb    (stb),
    .dac_we (dac_we)
  );

  // configuration words and digital output latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg1_q  <= '0;
      cfg2_q  <= '0;
      cfg3_q  <= '0;
      dio_out <= '0;
    end else begin
      if (stb.wr_cfg1) cfg1_q  <= bus_wdata;
      if (stb.wr_cfg2) cfg2_q  <= bus_wdata;
      if (stb.wr_cfg3) cfg3_q  <= bus_wdata;
      if (stb.wr_dout) dio_out <= bus_wdata[DIO_W-1:0];
    end
  end

  assign dio_oe = {{HALF{cfg3_q[OE_HI_BIT]}}, {HALF{cfg3_q[OE_LO_BIT]}}};

  // interrupt flags
  assign ev_v[FLG_TC]   = ev_tc;
  assign ev_v[FLG_INT1] = ev_int1;
  assign ev_v[FLG_INT2] = ev_int2;

  for (genvar f = 0; f < NFLG; f++) begin : g_flg
    aoc_flag u_flg (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_v[f]),
      .clr   (stb.clr[f]),
      .q     (flg[f])
    );
  end

  assign flag_tc   = flg[FLG_TC];
  assign flag_int1 = flg[FLG_INT1];
  assign flag_int2 = flg[FLG_INT2];

  aoc_dac_bank #(.NCH(NCH)) u_dac (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dac_we),
    .wdata (bus_wdata[DAC_W-1:0]),
    .vals  (dac_vals),
    .codes (dac_code)
  );

  // FIFO port
  assign fifo_wr_stb  = stb.fifo_wr;
  assign fifo_wdata   = bus_wdata;
  assign fifo_clr_stb = stb.fifo_clr;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_waddr)
        WI_DIO:  bus_rdata = {{(DW-DIO_W){1'b0}}, dio_in};
        WI_CFG1: bus_rdata = {9'b0, fifo_half, fifo_empty, fifo_full,
                              flg[FLG_INT2], flg[FLG_INT1], flg[FLG_TC], prom_dout};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/aoc_regbank_chk.sv
module aoc_regbank_chk
  import aoc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [WA_W-1:0] bus_waddr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   cfg1_q,
  input logic [DW-1:0]   cfg2_q,
  input logic            flag_tc,
  input logic            flag_int1,
  input logic            ev_int1,
  input logic            fifo_wr_stb,
  input logic            fifo_clr_stb
);
  logic alt;
  assign alt = cfg1_q[BANK_BIT];

  // R3
  alt_clr_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WI_DIO && alt) |=> !flag_tc);

  // R10
  ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_int1 && !(bus_wr && bus_waddr == WI_CFG2 && alt)) |=> flag_int1);

  // R2
  cfg2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WI_CFG2 && !alt) |=> (cfg2_q == $past(bus_wdata)));

  // R3
  alt_cfg2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_waddr == WI_CFG2 && alt) |=> $stable(cfg2_q));

  // R4
  fifo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_stb |-> (bus_wr && bus_waddr == WI_SHARE && !alt));

  // R7
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr_stb |-> (bus_rd && bus_waddr == WI_SHARE));
endmodule

bind aoc_regbank aoc_regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_waddr    (bus_waddr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .cfg1_q       (cfg1_q),
  .cfg2_q       (cfg2_q),
  .flag_tc      (flag_tc),
  .flag_int1    (flag_int1),
  .ev_int1      (ev_int1),
  .fifo_wr_stb  (fifo_wr_stb),
  .fifo_clr_stb (fifo_clr_stb)
);

// File: tb/aoc_regbank_tb.sv
module aoc_regbank_tb;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_waddr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic fifo_half = 0, fifo_empty = 0, fifo_full = 0, prom_dout = 0;
  logic ev_tc = 0, ev_int1 = 0, ev_int2 = 0;
  logic fifo_wr_stb, fifo_clr_stb;
  logic [15:0] fifo_wdata, cfg1_q, cfg2_q, cfg3_q;
  logic flag_tc, flag_int1, flag_int2;
  logic [NCH*12-1:0] dac_vals, dac_code;
  logic [7:0] dio_in = '0;
  logic [7:0] dio_out, dio_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aoc_regbank #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_half(fifo_half), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .prom_dout(prom_dout), .ev_tc(ev_tc), .ev_int1(ev_int1), .ev_int2(ev_int2),
    .fifo_wr_stb(fifo_wr_stb), .fifo_wdata(fifo_wdata), .fifo_clr_stb(fifo_clr_stb),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .cfg3_q(cfg3_q),
    .flag_tc(flag_tc), .flag_int1(flag_int1), .flag_int2(flag_int2),
    .dac_vals(dac_vals), .dac_code(dac_code),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] dac(int n);
    return dac_vals[n*12 +: 12];
  endfunction

  // one-cycle write; registered results visible on return
  task automatic bwrite(logic [4:0] off, logic [15:0] d);
    @(negedge clk);
    bus_waddr = off[4:1]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [4:0] off, output logic [15:0] d, output logic clr);
    @(negedge clk);
    bus_waddr = off[4:1]; bus_rd = 1'b1;
    #1 d = bus_rdata; clr = fifo_clr_stb;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg1", cfg1_q, 0);
    check("R1 cfg2", cfg2_q, 0);
    check("R1 cfg3", cfg3_q, 0);
    check("R1 flags", {flag_int2, flag_int1, flag_tc}, 0);
    check("R1 dio_oe", dio_oe, 0);
    check("R1 dio_out", dio_out, 0);
    for (int n = 0; n < NCH; n++) check("R1 dac", dac(n), 0);
  endtask

  task automatic t_normal();
    bwrite(5'h00, 16'h12A5);
    check("R2 dio_out", dio_out, 8'hA5);
    bwrite(5'h02, 16'hBEEF);
    check("R2 cfg2", cfg2_q, 16'hBEEF);
    bwrite(5'h04, 16'h0040);
    check("R2 cfg3", cfg3_q, 16'h0040);
    bwrite(5'h0A, 16'h0143);
    check("R2 cfg1", cfg1_q, 16'h0143);
  endtask

  task automatic t_dio();
    logic [15:0] d; logic c;
    bwrite(5'h04, 16'h0004);
    check("R9 oe low nibble", dio_oe, 8'h0F);
    bwrite(5'h04, 16'h0008);
    check("R9 oe high nibble", dio_oe, 8'hF0);
    dio_in = 8'h5C;
    bread(5'h00, d, c);
    check("R9 dio_in read", d, 16'h005C);
  endtask

  task automatic t_fifo();
    logic [15:0] d; logic c;
    @(negedge clk);
    bus_waddr = 4'd6; bus_wdata = 16'h0777; bus_wr = 1'b1;
    #1 check("R4 fifo_wr_stb", fifo_wr_stb, 1);
    check("R4 fifo_wdata", fifo_wdata, 16'h0777);
    @(negedge clk); bus_wr = 1'b0;
    check("R4 dac0 untouched", dac(0), 0);
    bread(5'h0C, d, c);
    check("R7 fifo_clr_stb", c, 1);
    check("R7 read data", d, 0);
    check("R7 dac0 unchanged", dac(0), 0);
  endtask

  task automatic t_alt();
    bwrite(5'h0A, 16'h0080);
    check("R3 bank set", cfg1_q, 16'h0080);
    @(negedge clk);
    ev_tc = 1; ev_int1 = 1; ev_int2 = 1;
    @(negedge clk);
    ev_tc = 0; ev_int1 = 0; ev_int2 = 0;
    check("R10 flags set", {flag_int2, flag_int1, flag_tc}, 3'b111);
    bwrite(5'h00, 16'h00FF);
    check("R3 tc cleared", flag_tc, 0);
    check("R3 dio_out kept", dio_out, 8'hA5);
    bwrite(5'h02, 16'h1111);
    check("R3 int1 cleared", flag_int1, 0);
    check("R3 cfg2 kept", cfg2_q, 16'hBEEF);
    bwrite(5'h04, 16'h2222);
    check("R3 int2 cleared", flag_int2, 0);
    check("R3 cfg3 kept", cfg3_q, 16'h0008);
    // clear and event in the same cycle
    @(negedge clk);
    bus_waddr = 4'd1; bus_wr = 1'b1; ev_int1 = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_int1 = 1'b0;
    check("R10 clear wins", flag_int1, 0);
    // DAC 0 in alternate bank, no FIFO strobe
    @(negedge clk);
    bus_waddr = 4'd6; bus_wdata = 16'hF801; bus_wr = 1'b1;
    #1 check("R4 no fifo strobe alt", fifo_wr_stb, 0);
    @(negedge clk); bus_wr = 1'b0;
    check("R4 dac0 loaded", dac(0), 12'h801);
    check("R6 dac0 code", dac_code[11:0], 12'h001);
    bwrite(5'h0A, 16'h0000);
  endtask

  task automatic t_dac();
    for (int n = 1; n < NCH; n++) bwrite(5'(12 + 2*n), 16'(16'h0100 * n + 16'h0A));
    for (int n = 1; n < NCH; n++) check("R5 dac n", dac(n), 12'(12'h100 * n + 12'h00A));
    check("R6 code ch1", dac_code[12 +: 12], 12'h90A);
    check("R6 code ch2", dac_code[24 +: 12], 12'hA0A);
    for (int n = NCH; n < 10; n++) bwrite(5'(12 + 2*n), 16'h0FFF);
    for (int n = 0; n < NCH; n++)
      check("R5 out-of-range ignored", dac(n), n == 0 ? 12'h801 : 12'(12'h100 * n + 12'h00A));
  endtask

  task automatic t_status();
    logic [15:0] d; logic c;
    fifo_half = 1; fifo_empty = 0; fifo_full = 1; prom_dout = 1;
    @(negedge clk); ev_int2 = 1; @(negedge clk); ev_int2 = 0;
    bread(5'h0A, d, c);
    check("R8 status", d, 16'b0000_0000_0101_1001);
    fifo_half = 0; fifo_full = 0; prom_dout = 0; fifo_empty = 1;
    bread(5'h0A, d, c);
    check("R8 status empty", d, 16'h0028);
  endtask

  task automatic t_ignored();
    logic [15:0] d; logic c;
    bwrite(5'h06, 16'hFFFF);
    bwrite(5'h08, 16'hFFFF);
    check("R11 cfg1 kept", cfg1_q, 0);
    check("R11 cfg2 kept", cfg2_q, 16'hBEEF);
    check("R11 cfg3 kept", cfg3_q, 16'h0008);
    check("R11 dio_out kept", dio_out, 8'hA5);
    bread(5'h02, d, c);
    check("R11 read zero", d, 0);
    bread(5'h06, d, c);
    check("R11 read zero timer", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_normal();
    t_dio();
    bwrite(5'h0A, 16'h0000);
    t_fifo();
    t_alt();
    t_dac();
    t_status();
    t_ignored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule